// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital half of a dual-slope integrating converter. It divides the master clock by four to get a count clock and runs a fixed frame of 4000 counts (16000 master clocks). Each frame passes through the same four phases. Signal integrate lasts 1000 counts. Reference de-integrate runs until the comparator reports a zero crossing, and at most 2000 counts. Zero-integrate discharges the integrator. Auto-zero then fills whatever time is left, so that the next signal integrate starts exactly one frame after the previous one. Each phase drives its own switch-enable output, and the de-integrate enable is split by polarity, so exactly one of five enables is high at any time.

During de-integrate a 3½-digit BCD counter counts the count-clock ticks that pass before the zero crossing is seen. The comparator state sampled at the end of signal integrate gives the input polarity. That polarity selects which de-integrate switch is driven and is reported as the sign of the reading. When de-integrate ends, the count and the sign are copied into an output latch and a valid strobe is raised for one clock. If the counter rolls over from 1999, the conversion is an overrange: the reading is forced to zero and the overrange flag is set. A separate zero-detect input ends zero-integrate early. After an overrange conversion, an integrator that has still not settled when the normal window closes earns a stretched zero-integrate.

The analog parts (integrator, comparator, reference and switches) lie outside the block.

Top module: `dslope_seq`

## Requirements
- R1: Reset (asynchronous, active low) forces auto-zero, clears the reading, overrange and valid outputs, and the first signal integrate starts 4000 master clocks after reset is released.
- R2: Exactly one of `sw_az`, `sw_int`, `sw_dep`, `sw_den`, `sw_zi` is high in every cycle.
- R3: Phases always follow the order auto-zero, signal integrate, de-integrate, zero-integrate, auto-zero.
- R4: Signal integrate lasts exactly 1000 count ticks, that is 4000 master clocks.
- R5: `cmp_pos` is sampled on the clock edge that ends signal integrate. A 1 selects `sw_dep` and latches `rd_neg`=0. A 0 selects `sw_den` and latches `rd_neg`=1.
- R6: A zero crossing means `cmp_pos` differs from its sampled value. If the crossing is first seen at the (N+1)th count tick of de-integrate, then de-integrate lasts 4(N+1) master clocks and the reading is N, for N from 0 to 1999.
- R7: If no crossing is seen in 2000 ticks, de-integrate ends after 8000 master clocks with `rd_ovr`=1 and all four reading digits equal to 0.
- R8: The reading, sign and overrange flag change only on the edge that ends de-integrate. `rd_valid` is high for exactly that one cycle.
- R9: Zero-integrate ends on the first clock with `zero_det`=1 once at least 11 master clocks have passed. If `zero_det` stays low, it ends after 140 master clocks.
- R10: When the conversion was an overrange and `zero_det` is still low at the 140th clock, zero-integrate lasts 740 master clocks.
- R11: Signal integrate begins every 16000 master clocks, whatever the reading.
- R12: The reading is BCD: `rd_ones`, `rd_tens` and `rd_hund` are 4-bit digits from 0 to 9, and `rd_thou` is the single leading digit (0 or 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_pos | input | 1 | Comparator: integrator output above zero |
| zero_det | input | 1 | Integrator has returned to zero (used in zero-integrate) |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_int | output | 1 | Signal integrate switch enable |
| sw_dep | output | 1 | De-integrate enable, reference set for a positive input |
| sw_den | output | 1 | De-integrate enable, reference set for a negative input |
| sw_zi | output | 1 | Zero-integrate switch enable |
| rd_thou | output | 1 | Latched leading digit |
| rd_hund | output | 4 | Latched hundreds digit |
| rd_tens | output | 4 | Latched tens digit |
| rd_ones | output | 4 | Latched units digit |
| rd_neg | output | 1 | Latched sign, 1 = negative |
| rd_ovr | output | 1 | Latched overrange flag |
| rd_valid | output | 1 | One-cycle strobe when a new reading is latched |

## Verification
The bench models the comparator by flipping `cmp_pos` a chosen number of ticks into de-integrate. It targets the readings 0, 1, 999, 1000 and 1999, and a missing crossing. A counter that is off by one tick would show 1 for a crossing at the first tick or miss 1999. A counter that mishandles the BCD carry would show wrong digits at 999 and 1000. One that wraps quietly would read 0000 with no overrange flag. Zero-integrate is driven with an immediate, a late and an absent zero-detect, both after normal readings and after overranges. A design that skips the minimum window, stretches on the wrong condition, or treats a settled integrator as heavy overrange produces a zero-integrate length other than 11, 51, 140 or 740. The frame spacing is measured on every conversion, because a design that let auto-zero stay fixed instead of absorbing the leftover time would drift with the reading.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int DIV         = 4,
  parameter int INT_COUNTS  = 1000,
  parameter int FRAME_COUNT = 4000,
  parameter int RESET_AZ    = 1000,
  parameter int ZI_MIN      = 11,
  parameter int ZI_NORM     = 140,
  parameter int ZI_HEAVY    = 740
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_pos,
  input  logic       zero_det,
  output logic       sw_az,
  output logic       sw_int,
  output logic       sw_dep,
  output logic       sw_den,
  output logic       sw_zi,
  output logic       rd_thou,
  output logic [3:0] rd_hund,
  output logic [3:0] rd_tens,
  output logic [3:0] rd_ones,
  output logic       rd_neg,
  output logic       rd_ovr,
  output logic       rd_valid
);

  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int FW = $clog2(FRAME_COUNT);
  localparam int ZW = $clog2(ZI_HEAVY + 1);
  localparam logic [PW-1:0] PRE_LAST   = PW'(DIV - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_COUNT - 1);
  localparam logic [FW-1:0] INT_LAST   = FW'(INT_COUNTS - 1);
  localparam logic [FW-1:0] FRAME_RST  = FW'(FRAME_COUNT - RESET_AZ);

  typedef enum logic [1:0] {PH_AZ, PH_INT, PH_DE, PH_ZI} phase_t;

  phase_t        phase;
  logic [PW-1:0] pre;
  logic [FW-1:0] frame_cnt;
  logic [ZW-1:0] zi_cnt;
  logic          pol_pos;
  logic [3:0]    c1, c10, c100;
  logic          c1000;

  logic       tick, crossed, wrap, zi_end;
  logic [3:0] n1, n10, n100;
  logic       n1000;

  assign tick    = (pre == PRE_LAST);
  assign crossed = (cmp_pos != pol_pos);

  assign sw_az  = (phase == PH_AZ);
  assign sw_int = (phase == PH_INT);
  assign sw_dep = (phase == PH_DE) &&  pol_pos;
  assign sw_den = (phase == PH_DE) && !pol_pos;
  assign sw_zi  = (phase == PH_ZI);

  always_comb begin
    n1 = c1; n10 = c10; n100 = c100; n1000 = c1000; wrap = 1'b0;
    if (c1 != 4'd9) n1 = c1 + 4'd1;
    else begin
      n1 = 4'd0;
      if (c10 != 4'd9) n10 = c10 + 4'd1;
      else begin
        n10 = 4'd0;
        if (c100 != 4'd9) n100 = c100 + 4'd1;
        else begin
          n100 = 4'd0;
          n1000 = ~c1000;
          wrap = c1000;
        end
      end
    end
  end

  assign zi_end = ((zi_cnt >= ZW'(ZI_MIN - 1)) && zero_det) ||
                  ((zi_cnt == ZW'(ZI_NORM - 1)) && !rd_ovr) ||
                  (zi_cnt == ZW'(ZI_HEAVY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_AZ;
      pre       <= '0;
      frame_cnt <= FRAME_RST;
      zi_cnt    <= '0;
      pol_pos   <= 1'b1;
      {c1000, c100, c10, c1} <= '0;
      {rd_thou, rd_hund, rd_tens, rd_ones} <= '0;
      rd_neg    <= 1'b0;
      rd_ovr    <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) frame_cnt <= (frame_cnt == FRAME_LAST) ? '0 : frame_cnt + FW'(1);
      case (phase)
        PH_AZ:
          if (tick && frame_cnt == FRAME_LAST) phase <= PH_INT;
        PH_INT:
          if (tick && frame_cnt == INT_LAST) begin
            phase   <= PH_DE;
            pol_pos <= cmp_pos;
            {c1000, c100, c10, c1} <= '0;
          end
        PH_DE:
          if (tick) begin
            if (crossed || wrap) begin
              phase    <= PH_ZI;
              zi_cnt   <= '0;
              rd_valid <= 1'b1;
              rd_neg   <= !pol_pos;
              rd_ovr   <= !crossed;
              if (crossed) {rd_thou, rd_hund, rd_tens, rd_ones} <= {c1000, c100, c10, c1};
              else         {rd_thou, rd_hund, rd_tens, rd_ones} <= '0;
            end else begin
              {c1000, c100, c10, c1} <= {n1000, n100, n10, n1};
            end
          end
        default:
          if (zi_end) phase <= PH_AZ;
          else        zi_cnt <= zi_cnt + ZW'(1);
      endcase
    end
  end

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sw_az, sw_int, sw_dep, sw_den, sw_zi})); // R2
  AST_INT_AFTER_AZ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_int) |-> $past(sw_az)); // R3
  AST_DE_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_dep || sw_den) |-> $past(sw_int)); // R3
  AST_ZI_AFTER_DE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_zi) |-> $past(sw_dep || sw_den)); // R3
  AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_int) |-> $past(frame_cnt) == INT_LAST); // R4
  AST_OVR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovr |-> ({rd_thou, rd_hund, rd_tens, rd_ones} == '0)); // R7
  AST_VALID_AT_DE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_dep || sw_den) |-> rd_valid); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R8
  AST_READING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable({rd_thou, rd_hund, rd_tens, rd_ones, rd_neg, rd_ovr})); // R8
  AST_ZI_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_zi) |-> $past(zi_cnt) >= ZW'(ZI_MIN - 1)); // R9
  AST_ZI_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sw_zi) && $past(zi_cnt) > ZW'(ZI_NORM - 1)) |-> rd_ovr); // R10
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ones <= 4'd9) && (rd_tens <= 4'd9) && (rd_hund <= 4'd9)); // R12

endmodule

// File: tb/dslope_seq_test.sv
`timescale 1ns/1ps
module dslope_seq_test;

  logic clk = 1'b0;
  logic rst_n, cmp_pos, zero_det;
  logic sw_az, sw_int, sw_dep, sw_den, sw_zi;
  logic rd_thou, rd_neg, rd_ovr, rd_valid;
  logic [3:0] rd_hund, rd_tens, rd_ones;

  int checks = 0;
  int fails = 0;
  int onehot_err = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dslope_seq uut (
    .clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .zero_det(zero_det),
    .sw_az(sw_az), .sw_int(sw_int), .sw_dep(sw_dep), .sw_den(sw_den), .sw_zi(sw_zi),
    .rd_thou(rd_thou), .rd_hund(rd_hund), .rd_tens(rd_tens), .rd_ones(rd_ones),
    .rd_neg(rd_neg), .rd_ovr(rd_ovr), .rd_valid(rd_valid)
  );

  // vector: [15] input positive, [14:13] zero-detect mode, [11:0] ticks to crossing (2000 = none)
  // mode 0: zero_det high at once, 1: never, 2: rises 50 clocks into zero-integrate
  localparam logic [15:0] VEC [0:7] = '{
    {1'b1, 2'd0, 1'b0, 12'd0},
    {1'b0, 2'd0, 1'b0, 12'd1},
    {1'b1, 2'd2, 1'b0, 12'd1999},
    {1'b0, 2'd1, 1'b0, 12'd2000},
    {1'b1, 2'd2, 1'b0, 12'd2000},
    {1'b1, 2'd1, 1'b0, 12'd999},
    {1'b0, 2'd0, 1'b0, 12'd1000},
    {1'b1, 2'd0, 1'b0, 12'd2000}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && ($countones({sw_az, sw_int, sw_dep, sw_den, sw_zi}) != 1)) onehot_err++;

  function automatic int reading(input int n);
    if (n >= 2000) return 0;
    return (n / 1000) * 4096 + ((n / 100) % 10) * 256 + ((n / 10) % 10) * 16 + n % 10;
  endfunction

  initial begin
    rst_n = 1'b0; cmp_pos = 1'b1; zero_det = 1'b0;
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11: got %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint last_int = 0;
    int c;
    repeat (3) @(negedge clk);
    check(sw_az && !sw_int && !sw_zi && !rd_valid, "R1 reset phase", sw_az, 1);
    check({rd_thou, rd_hund, rd_tens, rd_ones, rd_ovr, rd_neg} == '0, "R1 reset reading",
          {rd_thou, rd_hund, rd_tens, rd_ones}, 0);
    rst_n = 1'b1;
    c = 0;
    while (!sw_int) begin @(negedge clk); c++; end
    check(c == 4000, "R1 first integrate delay", c, 4000);

    for (int i = 0; i < 8; i++) begin
      bit pos;
      int mode, n, len, exp_zi, exp_rd;
      bit ovr;
      pos = VEC[i][15]; mode = int'(VEC[i][14:13]); n = int'(VEC[i][11:0]);
      ovr = (n >= 2000);
      exp_rd = reading(n);
      exp_zi = (mode == 0) ? 11 : (mode == 2) ? 51 : (ovr ? 740 : 140);
      while (!sw_int) @(negedge clk);
      if (i > 0) check(cyc - last_int == 16000, "R11 frame period", cyc - last_int, 16000);
      last_int = cyc;
      cmp_pos = pos;
      zero_det = (mode == 0);
      len = 0;
      while (sw_int) begin @(negedge clk); len++; end
      check(len == 4000, "R4 integrate length", len, 4000);
      check(sw_dep == pos && sw_den == !pos, "R5 reference polarity", sw_dep, pos);
      len = 0;
      while (sw_dep || sw_den) begin
        if (!ovr && len == 4 * n) cmp_pos = !pos;
        @(negedge clk);
        len++;
      end
      if (ovr) check(len == 8000, "R7 overrange de-integrate length", len, 8000);
      else     check(len == 4 * (n + 1), "R6 de-integrate length", len, 4 * (n + 1));
      check(rd_valid, "R8 valid strobe", rd_valid, 1);
      check({rd_thou, rd_hund, rd_tens, rd_ones} == 13'(exp_rd), ovr ? "R7 overrange digits" : "R6 R12 reading",
            {rd_thou, rd_hund, rd_tens, rd_ones}, exp_rd);
      check(rd_neg == !pos, "R5 sign", rd_neg, !pos);
      check(rd_ovr == ovr, "R7 overrange flag", rd_ovr, ovr);
      len = 0;
      while (sw_zi) begin
        if (len == 1) check(!rd_valid, "R8 strobe one cycle", rd_valid, 0);
        if (mode == 2 && len == 50) zero_det = 1'b1;
        @(negedge clk);
        len++;
      end
      check(len == exp_zi, (exp_zi == 740) ? "R10 stretched zero-integrate" : "R9 zero-integrate length",
            len, exp_zi);
      check(sw_az, "R3 auto-zero follows", sw_az, 1);
    end

    check(onehot_err == 0, "R2 one switch enable", onehot_err, 0);

    while (!sw_int) @(negedge clk);
    while (sw_int) @(negedge clk);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(sw_az && !sw_dep && !sw_den, "R1 reset mid de-integrate", sw_az, 1);
    check(!rd_ovr && {rd_thou, rd_hund, rd_tens, rd_ones} == '0, "R1 reset clears reading", rd_ovr, 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule